// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing front end of a 512-byte nonvolatile memory. It samples the two-wire clock and data lines with the system clock and finds start and stop conditions on them. It checks the select byte against a fixed device identifier and two strap pins. It then runs byte writes, page writes, current reads, random reads and sequential reads. The data line is driven only as an open-drain pull-down enable, for acknowledge slots and for read data.

Write bytes go out one at a time to a separate write-cycle controller, each with its target address. A stop hands over the whole burst with a commit pulse, and a start that interrupts a burst discards it with a cancel pulse. Read data comes from a synchronous read port whose address is the internal address counter. While the controller reports busy, the slave does not acknowledge its select byte, so a master can poll for completion.

Top module: `twi_eeprom_slave`

## Requirements
- R1: No select byte is acknowledged unless a start condition came before it. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After reset the pull-down enable and all strobes are low.
- R2: The pull-down enable changes only while SCL is low. The exception is a start or stop, which releases it.
- R3: A select byte is 8 bits, MSB first: bits 7..4 must be 1010, bits 3..2 must equal the strap pins, bit 1 is the half-select (upper address bit) and bit 0 is the direction (1 = read). On a mismatch the slave does not acknowledge, and it ignores the bus until the next start.
- R4: The slave acknowledges a matching select byte, each word-address byte and each write-data byte by pulling SDA low for the ninth clock.
- R5: While the write-cycle controller is busy, a select byte is not acknowledged. A commit never occurs while busy.
- R6: Each write-data byte gives one write strobe carrying the data and a 9-bit address made of the half-select bit and the word address. A stop after at least one data byte gives one commit pulse.
- R7: Within a write burst, each byte after the first goes to the previous address with its low 4 bits incremented modulo 16. The upper 5 bits stay the same.
- R8: A start that arrives while a write burst holds data gives a cancel pulse and no commit. This covers a repeated start and a start followed by a stop.
- R9: A random read (write-direction select, word address, repeated start, read-direction select) returns the byte at that address.
- R10: In a read, a master acknowledge (SDA low on the ninth clock) makes the slave send the next byte. The address wraps from 0x1FF to 0x000.
- R11: A master non-acknowledge ends the read. The slave leaves SDA released for any further clocks until the next start or stop.
- R12: After a read of address n, a current read returns address n+1. After a write burst whose last byte went to address n, a current read returns address n. The half-select bit of the read select byte gives the upper address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Device address strap pins |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rd_addr_o | output | 9 | Read port address (internal address counter) |
| rd_data_i | input | 8 | Read port data, one clock after the address |
| wc_busy_i | input | 1 | Write-cycle controller busy |
| wr_strobe_o | output | 1 | One-cycle pulse: a write byte is valid |
| wr_addr_o | output | 9 | Target address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the write cycle for the burst |
| wr_cancel_o | output | 1 | One-cycle pulse: discard the burst |

## Verification
The hardest case to reach from the ports is the page boundary: the address counter wraps inside a 16-byte page during a write, and across the whole array during a sequential read. The bench starts a six-byte burst four bytes below the end of a page. It also places known bytes at 0x1FF and 0x000 and then reads four bytes in sequence from 0x1FE. Busy polling is reached by issuing a select byte right after a stop, while the write-cycle model is still counting out its cycle time. Abort is reached by sending a start followed by a stop after one data byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_HOLD
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s      = scl_ff[STAGES-1];
   assign sda_s      = sda_ff[STAGES-1];
   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
   parameter int WORD_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_word_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              set_half_i,
   input  logic              half_i,
   input  logic              inc_seq_i,
   input  logic              inc_page_i,
   output logic [WORD_W:0]   ctr_o,
   output logic [WORD_W:0]   page_nxt_o
);
   localparam int ADDR_W = WORD_W + 1;

   if (PAGE_W < 1 || PAGE_W >= WORD_W) begin : g_bad_page
      $error("twi_addr_ctr: PAGE_W must lie in 1..WORD_W-1");
   end

   logic [ADDR_W-1:0] ctr;

   assign page_nxt_o = {ctr[ADDR_W-1:PAGE_W], ctr[PAGE_W-1:0] + 1'b1};
   assign ctr_o      = ctr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr <= '0;
      end else if (inc_seq_i) begin
         ctr <= ctr + 1'b1;
      end else if (inc_page_i) begin
         ctr <= page_nxt_o;
      end else begin
         if (ld_word_i)  ctr[WORD_W-1:0] <= word_i;
         if (set_half_i) ctr[WORD_W]     <= half_i;
      end
   end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int         PAGE_W      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_ID      = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_i,
   output logic       sda_oe_o,
   output logic [8:0] rd_addr_o,
   input  logic [7:0] rd_data_i,
   input  logic       wc_busy_i,
   output logic       wr_strobe_o,
   output logic [8:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic       wr_commit_o,
   output logic       wr_cancel_o
);
   import twi_pkg::*;

   localparam int WORD_W = 8;
   localparam int ADDR_W = WORD_W + 1;
   localparam logic [3:0] BYTE_DONE = 4'd8;

   twi_state_e        state;
   logic [3:0]        bcnt;
   logic [7:0]        sh, tx;
   logic              oe, rw, first_d, have_d, m_ack;
   logic              sda, scl_rise, scl_fall, start_det, stop_det;
   logic              fall_q, byte_end, sel_match;
   logic [ADDR_W-1:0] ctr, page_nxt;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_o(sda), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det)
   );

   assign fall_q    = scl_fall & ~start_det & ~stop_det;
   assign byte_end  = fall_q & (bcnt == BYTE_DONE);
   assign sel_match = (sh[7:4] == DEV_ID) && (sh[3:2] == strap_i) && !wc_busy_i;

   twi_addr_ctr #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .ld_word_i (byte_end && state == ST_WADDR),
      .word_i    (sh),
      .set_half_i(byte_end && state == ST_DEV && sel_match),
      .half_i    (sh[1]),
      .inc_seq_i (byte_end && state == ST_RDATA),
      .inc_page_i(byte_end && state == ST_WDATA && !first_d),
      .ctr_o     (ctr),
      .page_nxt_o(page_nxt)
   );

   assign rd_addr_o = ctr;
   assign sda_oe_o  = oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bcnt        <= '0;
         sh          <= '0;
         tx          <= '0;
         oe          <= 1'b0;
         rw          <= 1'b0;
         first_d     <= 1'b0;
         have_d      <= 1'b0;
         m_ack       <= 1'b0;
         wr_strobe_o <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         wr_commit_o <= 1'b0;
         wr_cancel_o <= 1'b0;
      end else begin
         wr_strobe_o <= 1'b0;
         wr_commit_o <= 1'b0;
         wr_cancel_o <= 1'b0;
         if (start_det) begin
            state       <= ST_DEV;
            bcnt        <= '0;
            oe          <= 1'b0;
            have_d      <= 1'b0;
            wr_cancel_o <= have_d;
         end else if (stop_det) begin
            state       <= ST_IDLE;
            oe          <= 1'b0;
            have_d      <= 1'b0;
            wr_commit_o <= have_d;
         end else begin
            if (scl_rise) begin
               unique case (state)
                  ST_DEV, ST_WADDR, ST_WDATA: begin
                     sh   <= {sh[6:0], sda};
                     bcnt <= bcnt + 4'd1;
                  end
                  ST_RDATA: bcnt  <= bcnt + 4'd1;
                  ST_RACK:  m_ack <= ~sda;
                  default: ;
               endcase
            end
            if (scl_fall) begin
               unique case (state)
                  ST_DEV: if (bcnt == BYTE_DONE) begin
                     if (sel_match) begin
                        oe    <= 1'b1;
                        rw    <= sh[0];
                        state <= ST_DEV_ACK;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
                  ST_DEV_ACK: begin
                     bcnt <= '0;
                     if (rw) begin
                        tx    <= {rd_data_i[6:0], 1'b0};
                        oe    <= ~rd_data_i[7];
                        state <= ST_RDATA;
                     end else begin
                        oe      <= 1'b0;
                        first_d <= 1'b1;
                        state   <= ST_WADDR;
                     end
                  end
                  ST_WADDR: if (bcnt == BYTE_DONE) begin
                     oe    <= 1'b1;
                     state <= ST_WADDR_ACK;
                  end
                  ST_WDATA: if (bcnt == BYTE_DONE) begin
                     oe          <= 1'b1;
                     wr_strobe_o <= 1'b1;
                     wr_addr_o   <= first_d ? ctr : page_nxt;
                     wr_data_o   <= sh;
                     first_d     <= 1'b0;
                     have_d      <= 1'b1;
                     state       <= ST_WDATA_ACK;
                  end
                  ST_WADDR_ACK, ST_WDATA_ACK: begin
                     oe    <= 1'b0;
                     bcnt  <= '0;
                     state <= ST_WDATA;
                  end
                  ST_RDATA: if (bcnt == BYTE_DONE) begin
                     oe    <= 1'b0;
                     state <= ST_RACK;
                  end else begin
                     tx <= {tx[6:0], 1'b0};
                     oe <= ~tx[7];
                  end
                  ST_RACK: if (m_ack) begin
                     tx    <= {rd_data_i[6:0], 1'b0};
                     oe    <= ~rd_data_i[7];
                     bcnt  <= '0;
                     state <= ST_RDATA;
                  end else begin
                     state <= ST_HOLD;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
   parameter int PAGE_W = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       sda_oe_o,
   input logic       wc_busy_i,
   input logic       wr_strobe_o,
   input logic [8:0] wr_addr_o,
   input logic       wr_commit_o,
   input logic       wr_cancel_o
);
   logic       scl_d, sda_d, in_burst;
   logic [8:0] last_addr;
   logic       raw_start;

   assign raw_start = scl_i & scl_d & sda_d & ~sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d     <= 1'b1;
         sda_d     <= 1'b1;
         in_burst  <= 1'b0;
         last_addr <= '0;
      end else begin
         scl_d <= scl_i;
         sda_d <= sda_i;
         if (raw_start || wr_commit_o || wr_cancel_o) begin
            in_burst <= 1'b0;
         end else if (wr_strobe_o) begin
            in_burst  <= 1'b1;
            last_addr <= wr_addr_o;
         end
      end
   end

   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i); // R2

   AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |-> !wc_busy_i); // R5

   AST_ONE_WRITE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_strobe_o, wr_commit_o, wr_cancel_o})); // R6

   AST_PAGE_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe_o && in_burst) |->
         (wr_addr_o[8:PAGE_W] == last_addr[8:PAGE_W]) &&
         (wr_addr_o[PAGE_W-1:0] == PAGE_W'(last_addr[PAGE_W-1:0] + 1'b1))); // R7
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sda_oe_o(sda_oe_o), .wc_busy_i(wc_busy_i), .wr_strobe_o(wr_strobe_o),
   .wr_addr_o(wr_addr_o), .wr_commit_o(wr_commit_o), .wr_cancel_o(wr_cancel_o)
);

// File: tb/tb_twi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twi_eeprom_slave;
   localparam int Q    = 10;
   localparam int BUSY = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic [1:0] strap = 2'b10;
   logic       sda_oe, wr_strobe, wr_commit, wr_cancel;
   logic [8:0] rd_addr, wr_addr;
   logic [7:0] rd_data, wr_data;
   logic       busy = 1'b0;
   wire        sda_bus = ~(m_low | sda_oe);

   always #4 clk = ~clk;

   twi_eeprom_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
      .sda_oe_o(sda_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wc_busy_i(busy), .wr_strobe_o(wr_strobe), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_commit_o(wr_commit), .wr_cancel_o(wr_cancel)
   );

   // memory array and write-cycle controller model
   logic [7:0] mem [0:511];
   logic [7:0] mm  [0:511];
   logic [8:0] st_a [$];
   logic [7:0] st_d [$];
   logic [8:0] strobe_log [$];
   int         busy_cnt = 0, commit_cnt = 0, cancel_cnt = 0, oe_viol = 0;
   int         n_chk = 0, n_fail = 0, mctr = 0;
   logic       oe_prev = 1'b0;
   bit         done = 0;

   initial for (int i = 0; i < 512; i++) begin mem[i] = 8'hFF; mm[i] = 8'hFF; end

   always @(posedge clk) rd_data <= mem[rd_addr];

   always @(posedge clk) begin
      if (wr_strobe) begin
         st_a.push_back(wr_addr); st_d.push_back(wr_data); strobe_log.push_back(wr_addr);
      end
      if (wr_cancel) begin st_a.delete(); st_d.delete(); cancel_cnt++; end
      if (wr_commit) begin commit_cnt++; busy <= 1'b1; busy_cnt = BUSY; end
      else if (busy) begin
         if (busy_cnt == 0) begin
            foreach (st_a[i]) mem[st_a[i]] = st_d[i];
            st_a.delete(); st_d.delete();
            busy <= 1'b0;
         end else busy_cnt--;
      end
      // every clock: enable may only move while SCL is low (R2)
      if (rst_n && (sda_oe !== oe_prev) && scl) oe_viol++;
      oe_prev = sda_oe;
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hq(); repeat (Q) @(negedge clk); endtask
   task automatic m_start(); m_low = 0; hq(); scl = 1; hq(); m_low = 1; hq(); scl = 0; hq(); endtask
   task automatic m_stop();  m_low = 1; hq(); scl = 1; hq(); m_low = 0; hq(); endtask
   task automatic wbit(bit b); m_low = !b; hq(); scl = 1; hq(); hq(); scl = 0; hq(); endtask
   task automatic rbit(output bit b);
      m_low = 0; hq(); scl = 1; hq(); b = sda_bus; hq(); scl = 0; hq();
   endtask
   task automatic send(logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b); ack = !b;
   endtask
   task automatic recv(bit ack_it, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
      wbit(!ack_it);
   endtask

   function automatic logic [7:0] sel(bit half, bit rd, logic [1:0] s);
      return {4'b1010, s, half, rd};
   endfunction

   task automatic poll(output bit first_nack);
      bit ack;
      first_nack = 0;
      for (int k = 0; k < 40; k++) begin
         m_start(); send(sel(0, 0, strap), ack); m_stop();
         if (k == 0) first_nack = !ack;
         if (ack) break;
      end
   endtask

   task automatic do_write(bit half, logic [7:0] word, logic [7:0] d [$], output bit all_ack,
                           output bit first_nack);
      bit ack; logic [8:0] a;
      all_ack = 1;
      m_start();
      send(sel(half, 0, strap), ack); all_ack &= ack;
      send(word, ack); all_ack &= ack;
      a = {half, word};
      foreach (d[i]) begin
         send(d[i], ack); all_ack &= ack;
         if (i != 0) a = {a[8:4], a[3:0] + 4'd1};
         mm[a] = d[i];
      end
      m_stop();
      mctr = a;
      poll(first_nack);
   endtask

   task automatic rand_read(bit half, logic [7:0] word, int n, ref logic [7:0] got [$]);
      bit ack; logic [7:0] v;
      got.delete();
      m_start(); send(sel(half, 0, strap), ack); send(word, ack);
      m_start(); send(sel(half, 1, strap), ack);
      for (int i = 0; i < n; i++) begin recv(i != n - 1, v); got.push_back(v); end
      m_stop();
      mctr = ({half, word} + n) % 512;
   endtask

   task automatic cur_read(bit half, ref logic [7:0] got);
      bit ack; logic [7:0] v;
      m_start(); send(sel(half, 1, strap), ack); recv(0, v); m_stop();
      got = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ack, all_ack, fnack, b;
      logic [7:0] got [$];
      logic [7:0] g1, ones;
      int ea, c0;

      repeat (5) @(negedge clk);
      check(sda_oe == 0 && wr_strobe == 0 && wr_commit == 0, "R1", "reset outputs", sda_oe, 0);
      rst_n = 1;
      repeat (5) @(negedge clk);

      // R1: select bits without a preceding start
      scl = 0; hq();
      send(sel(0, 0, strap), ack); m_stop();
      check(!ack, "R1", "ack without start", ack, 0);

      // R3: strap mismatch and identifier mismatch
      m_start(); send(sel(0, 0, 2'b01), ack); m_stop();
      check(!ack, "R3", "wrong strap ack", ack, 0);
      m_start(); send(8'hB4, ack); m_stop();
      check(!ack, "R3", "wrong id ack", ack, 0);

      // R4 R5 R6: byte write then busy polling
      strobe_log.delete(); c0 = commit_cnt;
      do_write(1, 8'h05, '{8'hA5}, all_ack, fnack);
      check(all_ack, "R4", "write acks", all_ack, 1);
      check(commit_cnt == c0 + 1, "R6", "commit count", commit_cnt - c0, 1);
      check(strobe_log.size() == 1 && strobe_log[0] == 9'h105, "R6", "strobe addr",
            strobe_log.size() ? strobe_log[0] : 0, 9'h105);
      check(fnack, "R5", "first poll during busy nacked", fnack, 1);
      check(!busy, "R5", "ack after busy ends", busy, 0);

      // R9 random read, R12 current read after read
      rand_read(1, 8'h05, 1, got);
      check(got[0] == 8'hA5, "R9", "random read 105", got[0], 8'hA5);
      ea = mctr;
      cur_read(1, g1);
      check(g1 == mm[ea], "R12", "current read after read", g1, mm[ea]);

      // R7 page write wrapping within 16 bytes, R12 current read after write
      strobe_log.delete();
      do_write(0, 8'h1C, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, all_ack, fnack);
      begin
         bit ok; logic [8:0] expa [$];
         expa = '{9'h01C, 9'h01D, 9'h01E, 9'h01F, 9'h010, 9'h011};
         ok = (strobe_log.size() == 6);
         foreach (expa[i]) if (ok && strobe_log[i] != expa[i]) ok = 0;
         check(ok, "R7", "page rollover addresses", strobe_log.size(), 6);
      end
      ea = mctr;
      cur_read(0, g1);
      check(g1 == mm[ea] && g1 == 8'h06, "R12", "current read after write", g1, 8'h06);

      // R10 sequential read across the top of the array
      do_write(1, 8'hFF, '{8'h3C}, all_ack, fnack);
      do_write(0, 8'h00, '{8'h5A}, all_ack, fnack);
      rand_read(1, 8'hFE, 4, got);
      check(got[0] == mm[9'h1FE], "R10", "seq byte 0", got[0], mm[9'h1FE]);
      check(got[1] == 8'h3C, "R10", "seq byte 1", got[1], 8'h3C);
      check(got[2] == 8'h5A, "R10", "seq wrap to 000", got[2], 8'h5A);
      check(got[3] == mm[9'h001], "R10", "seq byte 3", got[3], mm[9'h001]);

      // R8 abort by start plus stop
      c0 = commit_cnt;
      m_start(); send(sel(0, 0, strap), ack); send(8'h40, ack); send(8'h77, ack);
      m_start(); m_stop();
      repeat (20) @(negedge clk);
      check(commit_cnt == c0 && cancel_cnt >= 1, "R8", "abort commits", commit_cnt - c0, 0);
      rand_read(0, 8'h40, 1, got);
      check(got[0] == 8'hFF, "R8", "aborted byte unchanged", got[0], 8'hFF);

      // R11 master nack ends transmission
      m_start(); send(sel(1, 0, strap), ack); send(8'h05, ack);
      m_start(); send(sel(1, 1, strap), ack); recv(0, g1);
      for (int i = 7; i >= 0; i--) begin rbit(b); ones[i] = b; end
      m_stop();
      check(g1 == 8'hA5 && ones == 8'hFF, "R11", "bus released after nack", ones, 8'hFF);

      check(oe_viol == 0, "R2", "enable moved with SCL high", oe_viol, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule